// File: doc/BRIEF.md
# Data-Port Address Router

This block sits behind a command engine that moves values through one shared data port. The engine first loads one of two address registers, the primary or the alternate. Every value it then pushes through the data port is steered by whichever address register was loaded last. An address at or below 0xFFFF aims at the ordinary register file, and the register file write port receives the value. Any larger address aims at a bank of 256 pipe registers. The pipe index sits in the top byte of the address word, and bit 18 of that word freezes the address.

After each routed value the block moves the active address forward on its own. In register-file mode it adds one. In pipe mode it adds one to the top byte only, and it skips that step when bit 18 is set. A parameter mask marks some pipe registers as carrying no payload. Pointing an address register at one of these fires a zero-valued strobe right away. Three pipe indices form a small memory streamer: a low address word, a high address word and a data word. Each value written to the data word becomes a memory write request at the 64-bit address, and the address then moves forward by 4. All outputs are registered and appear one clock after the write that causes them.

Top module: `dataport_router`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every strobe output (`rf_we`, `pipe_we`, `mem_we`, `err`) is low. After reset both address registers hold zero and the primary register is active, so the first data write goes to register-file address 0.
- R2: `wr_sel` = 0 loads the primary address register and makes it active. `wr_sel` = 1 loads the alternate one and makes it active. Data writes (`wr_sel` = 2) use the active register until the next address load.
- R3: If the active address is at most 0xFFFF, a data write raises `rf_we` in the next cycle, with `rf_addr` equal to that address and `rf_wdata` equal to the data. The active address then increases by one, so 0xFFFF becomes 0x10000.
- R4: If the active address exceeds 0xFFFF and is legal, a data write raises `pipe_we` in the next cycle. `pipe_idx` equals address bits 31:24 and `pipe_wdata` equals the data.
- R5: In pipe mode with bit 18 clear, each data write adds 0x01000000 to the active address, and index 0xFF wraps to 0x00. With bit 18 set, the address does not change.
- R6: A pipe-mode address with any bit set other than bits 31:24 and bit 18 is illegal. A data write through such an address raises `err` in the next cycle, produces no register, pipe or memory write, and leaves the address unchanged. An address load with such a value also raises `err` and fires no zero-valued strobe.
- R7: Loading either address register with a legal pipe address whose index is set in `VOID_MASK` (default: indices 0x05 and 0x10) raises `pipe_we` in the next cycle, for that index, with data 0. Stepping onto such an index by auto-increment fires nothing.
- R8: Pipe writes to index 0x20 and 0x21 set the low and high halves of a 64-bit memory address. A pipe write to index 0x22 raises `mem_we` in the same cycle as `pipe_we`, with that address and the data. The address then increases by 4, with the carry going into the high half.
- R9: `wr_sel` = 3, or `wr_en` low, changes no state and raises no output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the command engine |
| wr_sel | input | 2 | 0 primary address, 1 alternate address, 2 data, 3 none |
| wr_data | input | 32 | Written value |
| rf_we | output | 1 | Register file write enable |
| rf_addr | output | 16 | Register file address |
| rf_wdata | output | 32 | Register file write data |
| pipe_we | output | 1 | Pipe register strobe |
| pipe_idx | output | 8 | Pipe register index |
| pipe_wdata | output | 32 | Pipe register data |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| err | output | 1 | Illegal pipe address used |

## Verification
A corrupted address register or a wrong active-register flag shows at the very next data write: the value lands at the wrong `rf_addr` or `pipe_idx`, or goes to the register file when it should have gone to the pipe bank. A wrong increment shows one write later, as a step other than +1, +0x01000000 or hold. A wrong memory-address counter shows at the next write to the data index, as a `mem_addr` that is not 4 past the previous one. Void-mask and legality errors show one cycle after the address load, as a missing or spurious zero strobe or `err` pulse.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    SEL_NADDR = 2'd0,
    SEL_UADDR = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_NONE  = 2'd3
  } sel_e;

  // Bits allowed to be set in a pipe-mode address: index byte plus hold bit.
  function automatic logic [31:0] pipe_legal_mask(input int idx_w, input int hold_bit);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i >= 32 - idx_w) m[i] = 1'b1;
    end
    m[hold_bit] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dpr_classify.sv
module dpr_classify #(
  parameter int DW       = 32,
  parameter int RF_AW    = 16,
  parameter int PIPE_IW  = 8,
  parameter int HOLD_BIT = 18
) (
  input  logic [DW-1:0]      val,
  output logic               is_pipe,
  output logic               legal,
  output logic               hold,
  output logic [PIPE_IW-1:0] idx
);
  localparam logic [DW-1:0] LEGAL = DW'(dpr_pkg::pipe_legal_mask(PIPE_IW, HOLD_BIT));

  always_comb begin
    is_pipe = |val[DW-1:RF_AW];
    legal   = ((val & ~LEGAL) == '0);
    hold    = val[HOLD_BIT];
    idx     = val[DW-1:DW-PIPE_IW];
  end
endmodule

// File: rtl/dpr_mem_stream.sv
module dpr_mem_stream #(
  parameter int DW           = 32,
  parameter int PIPE_IW      = 8,
  parameter int MAW          = 64,
  parameter int MEM_LO_IDX   = 8'h20,
  parameter int MEM_HI_IDX   = 8'h21,
  parameter int MEM_DATA_IDX = 8'h22,
  parameter int STEP         = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pw_en,
  input  logic [PIPE_IW-1:0] pw_idx,
  input  logic [DW-1:0]      pw_data,
  output logic               mem_we,
  output logic [MAW-1:0]     mem_addr,
  output logic [DW-1:0]      mem_wdata
);
  localparam int HW = MAW / 2;
  logic [MAW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (pw_en) begin
        if (pw_idx == PIPE_IW'(MEM_LO_IDX)) begin
          ptr_q[HW-1:0] <= HW'(pw_data);
        end else if (pw_idx == PIPE_IW'(MEM_HI_IDX)) begin
          ptr_q[MAW-1:HW] <= HW'(pw_data);
        end else if (pw_idx == PIPE_IW'(MEM_DATA_IDX)) begin
          mem_we    <= 1'b1;
          mem_addr  <= ptr_q;
          mem_wdata <= pw_data;
          ptr_q     <= ptr_q + MAW'(STEP);
        end
      end
    end
  end
endmodule

// File: rtl/dataport_router.sv
module dataport_router #(
  parameter int DW       = 32,
  parameter int RF_AW    = 16,
  parameter int PIPE_IW  = 8,
  parameter int HOLD_BIT = 18,
  parameter int MAW      = 64,
  parameter logic [(1<<PIPE_IW)-1:0] VOID_MASK =
    ((1<<PIPE_IW))'(1) << 5 | ((1<<PIPE_IW))'(1) << 16,
  parameter int MEM_LO_IDX   = 8'h20,
  parameter int MEM_HI_IDX   = 8'h21,
  parameter int MEM_DATA_IDX = 8'h22
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [DW-1:0]      wr_data,
  output logic               rf_we,
  output logic [RF_AW-1:0]   rf_addr,
  output logic [DW-1:0]      rf_wdata,
  output logic               pipe_we,
  output logic [PIPE_IW-1:0] pipe_idx,
  output logic [DW-1:0]      pipe_wdata,
  output logic               mem_we,
  output logic [MAW-1:0]     mem_addr,
  output logic [DW-1:0]      mem_wdata,
  output logic               err
);
  import dpr_pkg::*;

  localparam int            NADR    = 2;
  localparam logic [DW-1:0] IDX_INC = DW'(1) << (DW - PIPE_IW);

  logic [DW-1:0]      addr_q [NADR];
  logic [DW-1:0]      addr_d [NADR];
  logic               act_q, act_d;
  logic [DW-1:0]      cur;

  // Classification of the active address and of the incoming word.
  logic               c_pipe, c_legal, c_hold;
  logic [PIPE_IW-1:0] c_idx;
  logic               w_pipe, w_legal, w_hold;
  logic [PIPE_IW-1:0] w_idx;

  logic               rf_en, pw_en, err_d;
  logic [PIPE_IW-1:0] pw_idx;
  logic [DW-1:0]      pw_data;

  assign cur = addr_q[act_q];

  dpr_classify #(.DW(DW), .RF_AW(RF_AW), .PIPE_IW(PIPE_IW), .HOLD_BIT(HOLD_BIT)) u_cls_cur (
    .val(cur), .is_pipe(c_pipe), .legal(c_legal), .hold(c_hold), .idx(c_idx)
  );

  dpr_classify #(.DW(DW), .RF_AW(RF_AW), .PIPE_IW(PIPE_IW), .HOLD_BIT(HOLD_BIT)) u_cls_new (
    .val(wr_data), .is_pipe(w_pipe), .legal(w_legal), .hold(w_hold), .idx(w_idx)
  );

  always_comb begin
    addr_d  = addr_q;
    act_d   = act_q;
    rf_en   = 1'b0;
    pw_en   = 1'b0;
    err_d   = 1'b0;
    pw_idx  = c_idx;
    pw_data = wr_data;
    if (wr_en) begin
      case (wr_sel)
        SEL_NADDR, SEL_UADDR: begin
          addr_d[wr_sel[0]] = wr_data;
          act_d             = wr_sel[0];
          if (w_pipe) begin
            if (!w_legal) begin
              err_d = 1'b1;
            end else if (VOID_MASK[w_idx]) begin
              pw_en   = 1'b1;
              pw_idx  = w_idx;
              pw_data = '0;
            end
          end
        end
        SEL_DATA: begin
          if (!c_pipe) begin
            rf_en         = 1'b1;
            addr_d[act_q] = cur + DW'(1);
          end else if (!c_legal) begin
            err_d = 1'b1;
          end else begin
            pw_en = 1'b1;
            if (!c_hold) addr_d[act_q] = cur + IDX_INC;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NADR; i++) addr_q[i] <= '0;
      act_q      <= 1'b0;
      rf_we      <= 1'b0;
      rf_addr    <= '0;
      rf_wdata   <= '0;
      pipe_we    <= 1'b0;
      pipe_idx   <= '0;
      pipe_wdata <= '0;
      err        <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      act_q   <= act_d;
      rf_we   <= rf_en;
      pipe_we <= pw_en;
      err     <= err_d;
      if (rf_en) begin
        rf_addr  <= cur[RF_AW-1:0];
        rf_wdata <= wr_data;
      end
      if (pw_en) begin
        pipe_idx   <= pw_idx;
        pipe_wdata <= pw_data;
      end
    end
  end

  dpr_mem_stream #(
    .DW(DW), .PIPE_IW(PIPE_IW), .MAW(MAW),
    .MEM_LO_IDX(MEM_LO_IDX), .MEM_HI_IDX(MEM_HI_IDX), .MEM_DATA_IDX(MEM_DATA_IDX)
  ) u_mem (
    .clk(clk), .rst(rst), .pw_en(pw_en), .pw_idx(pw_idx), .pw_data(pw_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
  parameter int PIPE_IW      = 8,
  parameter int MAW          = 64,
  parameter int MEM_LO_IDX   = 8'h20,
  parameter int MEM_HI_IDX   = 8'h21,
  parameter int MEM_DATA_IDX = 8'h22
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [1:0]         wr_sel,
  input logic               rf_we,
  input logic               pipe_we,
  input logic [PIPE_IW-1:0] pipe_idx,
  input logic               mem_we,
  input logic [MAW-1:0]     mem_addr,
  input logic               err
);
  logic           rst_d = 1'b0;
  logic           seen_q;
  logic           moved_q;
  logic [MAW-1:0] last_q;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      AST_RESET_QUIET: assert (!rf_we && !pipe_we && !mem_we && !err); // R1
    end
    if (rst) begin
      seen_q  <= 1'b0;
      moved_q <= 1'b0;
      last_q  <= '0;
    end else begin
      if (pipe_we && (pipe_idx == PIPE_IW'(MEM_LO_IDX) || pipe_idx == PIPE_IW'(MEM_HI_IDX)))
        moved_q <= 1'b1;
      if (mem_we) begin
        if (seen_q && !moved_q) begin
          AST_MEM_STRIDE: assert (mem_addr == last_q + MAW'(4)); // R8
        end
        seen_q  <= 1'b1;
        moved_q <= 1'b0;
        last_q  <= mem_addr;
      end
    end
  end

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
    err |-> (!rf_we && !pipe_we && !mem_we)); // R6

  AST_MEM_VIA_PIPE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (pipe_we && pipe_idx == PIPE_IW'(MEM_DATA_IDX))); // R8

  AST_SEL_NONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3) |=> (!rf_we && !pipe_we && !mem_we && !err)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (!rf_we && !pipe_we && !err)); // R9

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    !(rf_we && (pipe_we || err))); // R3
endmodule

bind dataport_router dpr_checker #(
  .PIPE_IW(PIPE_IW), .MAW(MAW),
  .MEM_LO_IDX(MEM_LO_IDX), .MEM_HI_IDX(MEM_HI_IDX), .MEM_DATA_IDX(MEM_DATA_IDX)
) u_dpr_checker (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .rf_we(rf_we),
  .pipe_we(pipe_we), .pipe_idx(pipe_idx), .mem_we(mem_we), .mem_addr(mem_addr), .err(err)
);

// File: tb/test_dataport_router.sv
`timescale 1ns/1ps
module test_dataport_router;
  localparam real HALF = 2.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        rf_we, pipe_we, mem_we, err;
  logic [15:0] rf_addr;
  logic [31:0] rf_wdata, pipe_wdata, mem_wdata;
  logic [7:0]  pipe_idx;
  logic [63:0] mem_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(HALF) clk = ~clk;

  dataport_router i_dataport_router (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .pipe_we(pipe_we), .pipe_idx(pipe_idx), .pipe_wdata(pipe_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .err(err)
  );

  // Reference model state
  logic [31:0] m_addr [2];
  logic        m_act;
  logic [63:0] m_ptr;
  logic        e_rf, e_pipe, e_mem, e_err;
  logic [15:0] e_rfa;
  logic [31:0] e_rfd, e_pd, e_md;
  logic [7:0]  e_pi;
  logic [63:0] e_ma;

  function automatic bit is_void(input logic [7:0] i);
    return (i == 8'h05) || (i == 8'h10);
  endfunction

  function automatic bit legal(input logic [31:0] v);
    return (v & 32'h00FB_FFFF) == 32'h0;
  endfunction

  task automatic m_pipe(input logic [7:0] i, input logic [31:0] d);
    e_pipe = 1; e_pi = i; e_pd = d;
    if (i == 8'h20) m_ptr[31:0] = d;
    else if (i == 8'h21) m_ptr[63:32] = d;
    else if (i == 8'h22) begin
      e_mem = 1; e_ma = m_ptr; e_md = d; m_ptr = m_ptr + 64'd4;
    end
  endtask

  task automatic model(input logic [1:0] s, input logic [31:0] d);
    logic [31:0] a;
    e_rf = 0; e_pipe = 0; e_mem = 0; e_err = 0;
    if (s == 2'd0 || s == 2'd1) begin
      m_addr[s[0]] = d; m_act = s[0];
      if (d > 32'hFFFF) begin
        if (!legal(d)) e_err = 1;
        else if (is_void(d[31:24])) m_pipe(d[31:24], 32'h0);
      end
    end else if (s == 2'd2) begin
      a = m_addr[m_act];
      if (a <= 32'hFFFF) begin
        e_rf = 1; e_rfa = a[15:0]; e_rfd = d; m_addr[m_act] = a + 1;
      end else if (!legal(a)) e_err = 1;
      else begin
        m_pipe(a[31:24], d);
        if (!a[18]) m_addr[m_act] = a + 32'h0100_0000;
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input string tag, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    model(s, d);
    @(posedge clk);
    #1;
    wr_en = 0;
    chk(tag, "rf_we", rf_we, e_rf);
    if (e_rf) begin
      chk(tag, "rf_addr", rf_addr, e_rfa);
      chk(tag, "rf_wdata", rf_wdata, e_rfd);
    end
    chk(tag, "pipe_we", pipe_we, e_pipe);
    if (e_pipe) begin
      chk(tag, "pipe_idx", pipe_idx, e_pi);
      chk(tag, "pipe_wdata", pipe_wdata, e_pd);
    end
    chk(tag, "mem_we", mem_we, e_mem);
    if (e_mem) begin
      chk(tag, "mem_addr", mem_addr, e_ma);
      chk(tag, "mem_wdata", mem_wdata, e_md);
    end
    chk(tag, "err", err, e_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] idxs [7] = '{8'h05, 8'h10, 8'h20, 8'h21, 8'h22, 8'h30, 8'hFF};
    m_addr[0] = '0; m_addr[1] = '0; m_act = 0; m_ptr = '0;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1;
    // R1: quiet during reset
    chk("R1", "rf_we", rf_we, 0);
    chk("R1", "pipe_we", pipe_we, 0);
    chk("R1", "mem_we", mem_we, 0);
    chk("R1", "err", err, 0);
    @(negedge clk); rst = 0;
    wr("R1", 2'd2, 32'hA0A0_0001);       // first data to rf address 0
    wr("R3", 2'd2, 32'hA0A0_0002);       // then address 1
    wr("R2", 2'd0, 32'h0000_1234);
    wr("R3", 2'd2, 32'h11);
    wr("R3", 2'd2, 32'h22);
    wr("R2", 2'd1, 32'h0000_0080);
    wr("R2", 2'd2, 32'h33);              // alternate register active
    wr("R9", 2'd3, 32'hFFFF_FFFF);
    wr("R2", 2'd2, 32'h44);              // sel 3 left address at 0x81
    wr("R4", 2'd0, 32'h3000_0000);
    wr("R4", 2'd2, 32'hBEEF_0001);
    wr("R5", 2'd2, 32'hBEEF_0002);       // index 0x31
    wr("R5", 2'd1, 32'h3004_0000);
    wr("R5", 2'd2, 32'h1);
    wr("R5", 2'd2, 32'h2);               // held at 0x30
    wr("R5", 2'd0, 32'hFF00_0000);
    wr("R5", 2'd2, 32'h5);               // index 0xFF, wraps to 0
    wr("R5", 2'd2, 32'h6);               // address 0 -> register file
    wr("R7", 2'd0, 32'h0500_0000);       // void strobe
    wr("R7", 2'd1, 32'h0400_0000);
    wr("R7", 2'd2, 32'h77);              // steps onto void index 5
    wr("R7", 2'd3, 32'h0);               // nothing fires
    wr("R7", 2'd2, 32'h78);
    wr("R6", 2'd0, 32'h1000_0100);       // illegal load: err, no void strobe
    wr("R6", 2'd2, 32'h99);
    wr("R6", 2'd2, 32'h9A);              // address unchanged, still err
    wr("R6", 2'd1, 32'h0000_FFFF);
    wr("R6", 2'd2, 32'h1);               // rf 0xFFFF
    wr("R6", 2'd2, 32'h2);               // 0x10000 is illegal pipe
    wr("R8", 2'd0, 32'h2004_0000);
    wr("R8", 2'd2, 32'hFFFF_FFF8);
    wr("R8", 2'd0, 32'h2104_0000);
    wr("R8", 2'd2, 32'h0000_0001);
    wr("R8", 2'd0, 32'h2204_0000);
    wr("R8", 2'd2, 32'hD1);
    wr("R8", 2'd2, 32'hD2);
    wr("R8", 2'd2, 32'hD3);              // carry into high half
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [31:0] v;
      r = $urandom % 16;
      if (r < 3) wr("R3", 2'($urandom % 2), ($urandom % 8 == 0) ? 32'hFFFF : ($urandom & 32'hFFFF));
      else if (r < 7) begin
        v = {idxs[$urandom % 7], 24'h0};
        if ($urandom % 2) v[18] = 1'b1;
        if (v == 32'h0) v[18] = 1'b1;
        wr("R4", 2'($urandom % 2), v);
      end
      else if (r == 7) wr("R6", 2'($urandom % 2), 32'h4000_0000 | (32'h1 << ($urandom % 18)));
      else if (r == 8) wr("R9", 2'd3, $urandom);
      else wr("R4", 2'd2, $urandom);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule